// File: doc/BRIEF.md
# Four-Word Receive Buffer with Newest-Slot Overwrite

This block sits behind a serial word receiver, one instance per channel. Each time the acceptance logic upstream decides that a received 32-bit word should be kept, it pulses a load strobe with the word. The block keeps up to four such words in arrival order. A host reads them one at a time with a read strobe, and each word appears on a registered output one cycle after its strobe.

Three status outputs describe the buffer. A data-ready flag is raised by any load and drops once the last held word has been read. An empty bit shows that no words are held, and a full bit shows that all four slots are occupied. If a host falls behind and a fifth word arrives while the buffer is full, the block keeps the three oldest words and replaces the most recently stored one with the newcomer. When a read comes in the same cycle, the read frees a slot first and the new word is stored in the normal way.

Top module: `rxq_overwrite_buf`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `buf_empty` is 1, `buf_full` is 0, `data_rdy` is 0 and `rd_word` is 0.
- R2: A cycle with `ld_valid` high leaves `data_rdy` at 1 and `buf_empty` at 0 on the following cycle.
- R3: `buf_empty` stays 0 until every held word has been read out. Loads never set it.
- R4: `buf_full` is 1 exactly when four words are held.
- R5: Reads return words oldest first. The word taken by a read strobe appears on `rd_word` in the cycle after the strobe and is held there until the next successful read.
- R6: A load with no read while four words are held replaces the most recently stored word. The three older words and their order are kept, and `buf_full` stays 1.
- R7: A read strobe on an empty buffer leaves `rd_word`, `buf_empty`, `buf_full` and `data_rdy` unchanged.
- R8: A load and a read in the same cycle on a full buffer returns the oldest word and appends the new word at the tail with no overwrite. The buffer stays full.
- R9: `data_rdy` falls to 0 in the same cycle that `buf_empty` rises to 1.
- R10: A load and a read in the same cycle on an empty buffer stores the word, leaves `rd_word` unchanged, and results in exactly one held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Store `ld_word` this cycle |
| ld_word | input | 32 | Word to store |
| rd_req | input | 1 | Take the oldest held word |
| rd_word | output | 32 | Last word read, registered |
| data_rdy | output | 1 | Set by a load, cleared when the buffer empties |
| buf_empty | output | 1 | No words held |
| buf_full | output | 1 | Four words held |

## Verification
The properties assume that `ld_valid` and `rd_req` are clean single-cycle strobes that may be asserted in any combination in any cycle. They also assume that `ld_word` is only meaningful when `ld_valid` is high. The stimulus holds every input constant across each rising edge, changing them only at falling edges. Beyond the random mix, directed phases push the buffer into each corner the properties rely on: reads on an empty buffer, repeated loads on a full one, and simultaneous load and read at both the empty and the full boundaries.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_WORD_W = 32;
    localparam int unsigned RXQ_DEPTH  = 4;

    // What the buffer does with the current pair of strobes
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PUSH,
        ACT_POP,
        ACT_POP_PUSH,
        ACT_REPLACE
    } rxq_act_e;

    // Circular pointer step for any depth
    function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

    function automatic int unsigned ring_prev(int unsigned p, int unsigned depth);
        return (p == 0) ? depth - 1 : p - 1;
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic             rd_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_addr,
    output logic             data_rdy,
    output logic             buf_empty,
    output logic             buf_full
);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;
    rxq_act_e         act;
    logic             has_word;
    logic             is_full;

    assign has_word = (cnt_q != '0);
    assign is_full  = (cnt_q == CNT_W'(DEPTH));

    always_comb begin
        if (rd_req && has_word && ld_valid) act = ACT_POP_PUSH;
        else if (rd_req && has_word)        act = ACT_POP;
        else if (ld_valid && is_full)       act = ACT_REPLACE;
        else if (ld_valid)                  act = ACT_PUSH;
        else                                act = ACT_IDLE;
    end

    always_comb begin
        wr_en   = ld_valid;
        rd_en   = (act == ACT_POP) || (act == ACT_POP_PUSH);
        rd_addr = head_q;
        if (act == ACT_REPLACE)
            wr_addr = PTR_W'(ring_prev(int'(tail_q), DEPTH));
        else
            wr_addr = tail_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (act)
                ACT_PUSH: begin
                    tail_q <= PTR_W'(ring_next(int'(tail_q), DEPTH));
                    cnt_q  <= cnt_q + 1'b1;
                end
                ACT_POP: begin
                    head_q <= PTR_W'(ring_next(int'(head_q), DEPTH));
                    cnt_q  <= cnt_q - 1'b1;
                end
                ACT_POP_PUSH: begin
                    head_q <= PTR_W'(ring_next(int'(head_q), DEPTH));
                    tail_q <= PTR_W'(ring_next(int'(tail_q), DEPTH));
                end
                default: ;
            endcase
        end
    end

    // Ready flag: raised by any load, dropped by the read that drains the last word
    always_ff @(posedge clk) begin
        if (rst)
            data_rdy <= 1'b0;
        else if (ld_valid)
            data_rdy <= 1'b1;
        else if (act == ACT_POP && cnt_q == CNT_W'(1))
            data_rdy <= 1'b0;
    end

    assign buf_empty = !has_word;
    assign buf_full  = is_full;

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned WORD_W = RXQ_WORD_W,
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0]  slot_we;

    // One write-enable per slot, decoded from the write address
    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign slot_we[g] = wr_en && (wr_addr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i])
                slot_q[i] <= wr_data;
        end
    end

    // Output register: updated only by a read that finds a word
    always_ff @(posedge clk) begin
        if (rst)
            rd_word <= '0;
        else if (rd_en)
            rd_word <= slot_q[rd_addr];
    end

endmodule

// File: rtl/rxq_overwrite_buf.sv
module rxq_overwrite_buf
    import rxq_pkg::*;
#(
    parameter int unsigned WORD_W = RXQ_WORD_W,
    parameter int unsigned DEPTH  = RXQ_DEPTH,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              rd_req,
    output logic [WORD_W-1:0] rd_word,
    output logic              data_rdy,
    output logic              buf_empty,
    output logic              buf_full
);

    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_addr, rd_addr;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ld_valid  (ld_valid),
        .rd_req    (rd_req),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .data_rdy  (data_rdy),
        .buf_empty (buf_empty),
        .buf_full  (buf_full)
    );

    rxq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (ld_word),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

endmodule

// File: rtl/rxq_overwrite_buf_chk.sv
module rxq_overwrite_buf_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_valid,
    input logic [WORD_W-1:0] ld_word,
    input logic              rd_req,
    input logic [WORD_W-1:0] rd_word,
    input logic              data_rdy,
    input logic              buf_empty,
    input logic              buf_full
);

    // R2
    load_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> (data_rdy && !buf_empty));

    // R3
    hold_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (!buf_empty && !rd_req) |=> !buf_empty);

    // R4
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(buf_full && buf_empty));

    // R6
    replace_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_full && ld_valid && !rd_req) |=> buf_full);

    // R7
    empty_read_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_empty && rd_req && !ld_valid) |=>
            ($stable(rd_word) && buf_empty && !data_rdy));

    // R8
    full_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_full && ld_valid && rd_req) |=> buf_full);

    // R9
    ready_tracks_empty_chk: assert property (@(posedge clk) disable iff (rst)
        data_rdy == !buf_empty);

    // R10
    empty_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_empty && ld_valid && rd_req) |=> ($stable(rd_word) && !buf_empty));

endmodule

bind rxq_overwrite_buf rxq_overwrite_buf_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/rxq_overwrite_buf_bench.sv
`timescale 1ns/1ps
module rxq_overwrite_buf_bench;

    localparam int W = 32;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_valid = 1'b0;
    logic [W-1:0] ld_word = '0;
    logic         rd_req = 1'b0;
    logic [W-1:0] rd_word;
    logic         data_rdy, buf_empty, buf_full;

    int    n_checks = 0;
    int    n_fails  = 0;
    string phase    = "R1";
    bit    done     = 1'b0;

    // Behavioural reference
    logic [W-1:0] model_q[$];
    logic [W-1:0] exp_word = '0;

    always #2.5 clk = ~clk;

    rxq_overwrite_buf u_rxq_overwrite_buf (.*);

    always @(posedge clk) begin
        if (rst) begin
            model_q.delete();
            exp_word = '0;
        end else begin
            if (rd_req && model_q.size() > 0)
                exp_word = model_q.pop_front();
            if (ld_valid) begin
                if (model_q.size() == D) model_q[D-1] = ld_word;
                else                     model_q.push_back(ld_word);
            end
        end
    end

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare against the reference on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(phase, "rd_word (R5)", rd_word, exp_word);
            check(phase, "buf_empty (R3)", W'(buf_empty), W'(model_q.size() == 0));
            check(phase, "buf_full (R4)", W'(buf_full), W'(model_q.size() == D));
            check(phase, "data_rdy (R9)", W'(data_rdy), W'(model_q.size() != 0));
        end
    end

    // Called just after a falling edge; returns at the next falling edge
    task automatic step(bit ld, logic [W-1:0] w, bit rd);
        ld_valid = ld;
        ld_word  = w;
        rd_req   = rd;
        @(negedge clk);
        ld_valid = 1'b0;
        rd_req   = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", "rd_word", rd_word, '0);
        check("R1", "buf_empty", W'(buf_empty), 1);
        check("R1", "buf_full", W'(buf_full), 0);
        check("R1", "data_rdy", W'(data_rdy), 0);
        rst = 1'b0;
        @(negedge clk);

        // R7: reads with nothing held
        phase = "R7";
        repeat (3) step(0, '0, 1);
        check("R7", "rd_word", rd_word, '0);

        // R10: load and read together on an empty buffer
        phase = "R10";
        step(1, 32'hA5A5_0001, 1);
        check("R10", "rd_word", rd_word, '0);
        check("R10", "buf_empty", W'(buf_empty), 0);
        step(0, '0, 1);
        check("R10", "drained word", rd_word, 32'hA5A5_0001);
        check("R9", "data_rdy after drain", W'(data_rdy), 0);

        // R2, R3, R5: three loads then drain in order
        phase = "R2";
        step(1, 32'h1111_0000, 0);
        check("R2", "data_rdy", W'(data_rdy), 1);
        step(1, 32'h2222_0000, 0);
        step(1, 32'h3333_0000, 0);
        phase = "R5";
        step(0, '0, 1);
        check("R5", "first out", rd_word, 32'h1111_0000);
        step(0, '0, 1);
        check("R3", "still non-empty", W'(buf_empty), 0);
        step(0, '0, 1);
        check("R5", "third out", rd_word, 32'h3333_0000);
        check("R9", "empty after drain", W'(buf_empty), 1);

        // R4, R6: fill, then overwrite the newest twice
        phase = "R6";
        for (int i = 0; i < D; i++) step(1, 32'hC000_0000 + i, 0);
        check("R4", "full at four", W'(buf_full), 1);
        step(1, 32'hEEEE_0001, 0);
        step(1, 32'hEEEE_0002, 0);
        check("R6", "still full", W'(buf_full), 1);
        for (int i = 0; i < D - 1; i++) begin
            step(0, '0, 1);
            check("R6", "older word kept", rd_word, 32'hC000_0000 + i);
        end
        step(0, '0, 1);
        check("R6", "newest replaced", rd_word, 32'hEEEE_0002);

        // R8: load and read together while full
        phase = "R8";
        for (int i = 0; i < D; i++) step(1, 32'hD000_0000 + i, 0);
        step(1, 32'hF000_0001, 1);
        check("R8", "oldest out", rd_word, 32'hD000_0000);
        check("R8", "still full", W'(buf_full), 1);
        step(1, 32'hF000_0002, 1);
        for (int i = 0; i < D; i++) step(0, '0, 1);
        check("R8", "appended word kept", rd_word, 32'hF000_0002);

        // Mixed traffic against the reference
        phase = "R5 random";
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) != 0, $urandom, ($urandom % 2) == 0);
        for (int i = 0; i < D + 1; i++) step(0, '0, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule